// File: doc/BRIEF.md
# Guarded Register Update Combiner

This block merges the next-state proposals of several rules that all target one shared register. Each rule offers a guard bit, which says it wants to write, and a candidate value. A priority scheduler turns the guards into fire signals, at most one of which is active in a cycle. The register's write enable and its next value are built from these fire signals, never from the raw guards. When several guards are active at once, the register therefore receives exactly one rule's value and never a bitwise mix of several.

The scheduler lets one rule through per cycle and is conservative by design: the rule with the lowest index wins. The fire vector is combinational and is visible in the same cycle as the guards. The register changes only on the rising clock edge, so a rule always reads the value left by earlier cycles. With no guard active, the register keeps its value.

Top module: `guarded_update_combiner`

## Requirements
- R1: While `rst_n` is low, and after it is released, `reg_value` is zero until the first update.
- R2: At most one bit of `fire` is high in any cycle.
- R3: A bit of `fire` is high only if the guard bit with the same index is high.
- R4: When guards are active, the fire bit of the lowest-index active guard is set. Bit 0 has the highest priority.
- R5: When at least one guard is high, exactly one fire bit is high in the same cycle.
- R6: At the rising edge that ends a cycle in which rule i fires, `reg_value` takes the data slice `rule_data[i*DATA_W +: DATA_W]` for that rule.
- R7: In a cycle with all guards low, `reg_value` keeps its value across the following edge.
- R8: When several guards are high and their data differ, the stored value is exactly the winner's data, not the OR of the contenders' data.
- R9: The data slices of rules that do not fire have no effect on `reg_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_guard | input | NUM_RULES | Guard bit of each rule; bit i belongs to rule i |
| rule_data | input | NUM_RULES*DATA_W | Proposed values; rule i uses bits [i*DATA_W +: DATA_W] |
| fire | output | NUM_RULES | One-hot-or-zero fire vector from the scheduler |
| reg_value | output | DATA_W | Current value of the shared register |

## Verification
The fire vector is a combinational function of the guards and is due in the same cycle. The bench drives the inputs just after a falling edge and compares `fire` one time unit later, before the next rising edge. The register result is due one rising edge after the cycle in which its rule fired. The bench updates its model at that edge and compares `reg_value` one time unit after it, while the inputs of that cycle are still held. Directed cases with conflicting data and with all guards low then test priority, the absence of mixing, and the hold behaviour.

// File: rtl/guc_pkg.sv
package guc_pkg;
  localparam int GUC_RULES_DEFAULT = 4;
  localparam int GUC_WIDTH_DEFAULT = 8;
endpackage

// File: rtl/guc_priority_sched.sv
module guc_priority_sched #(
  parameter int NUM_RULES = guc_pkg::GUC_RULES_DEFAULT
) (
  input  logic [NUM_RULES-1:0] guard,
  output logic [NUM_RULES-1:0] fire
);
  // seen[i] is high when some rule below index i has a true guard
  logic [NUM_RULES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_chain
    assign seen[i+1] = seen[i] | guard[i];
    assign fire[i]   = guard[i] & ~seen[i];
  end
endmodule

// File: rtl/guc_merge.sv
module guc_merge #(
  parameter int NUM_RULES = guc_pkg::GUC_RULES_DEFAULT,
  parameter int DATA_W    = guc_pkg::GUC_WIDTH_DEFAULT
) (
  input  logic [NUM_RULES-1:0]        fire,
  input  logic [NUM_RULES*DATA_W-1:0] data,
  output logic                        wr_en,
  output logic [DATA_W-1:0]           next_val
);
  logic [DATA_W-1:0] gated [NUM_RULES];

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_gate
    assign gated[i] = data[i*DATA_W +: DATA_W] & {DATA_W{fire[i]}};
  end

  always_comb begin
    next_val = '0;
    for (int i = 0; i < NUM_RULES; i++) begin
      next_val = next_val | gated[i];
    end
  end

  assign wr_en = |fire;
endmodule

// File: rtl/guc_state_reg.sv
module guc_state_reg #(
  parameter int DATA_W = guc_pkg::GUC_WIDTH_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/guarded_update_combiner.sv
module guarded_update_combiner #(
  parameter int NUM_RULES = guc_pkg::GUC_RULES_DEFAULT,
  parameter int DATA_W    = guc_pkg::GUC_WIDTH_DEFAULT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_RULES-1:0]        rule_guard,
  input  logic [NUM_RULES*DATA_W-1:0] rule_data,
  output logic [NUM_RULES-1:0]        fire,
  output logic [DATA_W-1:0]           reg_value
);
  logic              wr_en;
  logic [DATA_W-1:0] next_val;

  guc_priority_sched #(.NUM_RULES(NUM_RULES)) u_sched (
    .guard (rule_guard),
    .fire  (fire)
  );

  guc_merge #(.NUM_RULES(NUM_RULES), .DATA_W(DATA_W)) u_merge (
    .fire     (fire),
    .data     (rule_data),
    .wr_en    (wr_en),
    .next_val (next_val)
  );

  guc_state_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wr_en),
    .d     (next_val),
    .q     (reg_value)
  );
endmodule

// File: rtl/guc_checker.sv
module guc_checker #(
  parameter int NUM_RULES = 4,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RULES-1:0] guard,
  input logic [NUM_RULES-1:0] fire,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    next_val,
  input logic [DATA_W-1:0]    reg_value
);
  // R2
  fire_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  // R3
  fire_within_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & ~guard) == '0);

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> (((fire - 1'b1) & guard) == '0));

  // R5
  someone_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != '0) |-> ($countones(fire) == 1));

  // R6
  update_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_value == $past(next_val)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard == '0) |=> $stable(reg_value));
endmodule

bind guarded_update_combiner guc_checker #(
  .NUM_RULES(NUM_RULES), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .guard     (rule_guard),
  .fire      (fire),
  .wr_en     (wr_en),
  .next_val  (next_val),
  .reg_value (reg_value)
);

// File: tb/guarded_update_combiner_test.sv
module guarded_update_combiner_test;
  localparam int N = 4;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   g = '0;
  logic [N*W-1:0] d = '0;
  logic [N-1:0]   fire;
  logic [W-1:0]   reg_value;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guarded_update_combiner #(.NUM_RULES(N), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rule_guard(g), .rule_data(d),
    .fire(fire), .reg_value(reg_value)
  );

  // Scan from rule 0 upward and stop at the first true guard
  function automatic logic [N-1:0] want_fire(logic [N-1:0] gv);
    for (int i = 0; i < N; i++) if (gv[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [W-1:0] want_reg(logic [W-1:0] cur, logic [N-1:0] gv,
                                            logic [N*W-1:0] dv);
    for (int i = 0; i < N; i++) if (gv[i]) return dv[i*W +: W];
    return cur;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [N-1:0] gv, logic [N*W-1:0] dv, string req);
    @(negedge clk);
    g = gv; d = dv;
    #1;
    cmp({req, "/R2-fire"}, 32'(fire), 32'(want_fire(gv)));
    model = want_reg(model, gv, dv);
    @(posedge clk);
    #1;
    cmp(req, 32'(reg_value), 32'(model));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset value
    repeat (2) @(negedge clk);
    g = '1; d = '1;
    #1 cmp("R1 in reset", 32'(reg_value), 32'h0);
    @(negedge clk);
    g = '0; rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R1 after release", 32'(reg_value), 32'h0);

    // R6: each rule alone
    for (int i = 0; i < N; i++) begin
      logic [N*W-1:0] dv = '0;
      dv[i*W +: W] = W'(8'h11 * (i + 1));
      step(N'(1) << i, dv, "R6 single rule");
    end
    // R7: idle keeps value, with busy data
    step('0, {N{8'hFF}}, "R7 idle hold");
    step('0, {N{8'h5A}}, "R7 idle hold again");
    // R8: all guards, conflicting data -> rule 0 data only
    step('1, {8'hF0, 8'h0F, 8'hC3, 8'h3C}, "R8 no mixing");
    // R4: rules 1 and 3 contend
    step(4'b1010, {8'hAA, 8'h77, 8'h55, 8'h99}, "R4 priority");
    // R9: losing and idle rules carry other data
    step(4'b0100, {8'hEE, 8'h21, 8'hDD, 8'hCC}, "R9 others ignored");
    step(4'b1000, {8'h42, 8'hFF, 8'hFF, 8'hFF}, "R5 top rule alone");

    // R3 / R5 / R6: random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0]   gv = N'($urandom);
      logic [N*W-1:0] dv = {$urandom};
      if ($urandom_range(0, 4) == 0) gv = '0;
      step(gv, dv, "R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule